// File: doc/BRIEF.md
# Custom Glyph Store Host Port

This block is the host-facing side of a store for user-defined glyphs on a 5x7 dot-matrix display. It has sixteen glyph slots. Each slot holds seven rows of five dots. A host reaches the store through a strobed bus: a region select line, a 5-bit address, an 8-bit data bus, and active-low chip enable, write, read and reset. A slot pointer register selects the glyph being edited. The host loads the slot pointer first. It then writes the rows one per bus cycle, with the low address bits naming the row. A complete glyph therefore takes eight writes. For example, a capital F is entered as the rows 1F, 10, 10, 1E, 10, 10, 10.

The host can read back both the slot pointer and any row of the current slot. The read result appears on a registered output one clock after the read is seen. A separate combinational port lets a display scanner fetch any row of any slot without involving the bus. All bus inputs are sampled on the system clock, and a write takes effect when the sampled write strobe rises.

Top module: `glyph_ram_port`

## Requirements
- R1: While `host_rst_n` is low at a clock edge, the slot pointer clears to 0 and `host_rdata` clears to 0. After reset, a read of the pointer region returns 0.
- R2: A write with `region_sel`=1, `addr[4]`=0 and `addr[3]`=0 loads `din[3:0]` into the slot pointer. `din[7:4]` are ignored, and a pointer readback returns them as 0.
- R3: A write with `region_sel`=1, `addr[4]`=0 and `addr[3]`=1 stores `din[4:0]` as row `addr[2:0]` of the slot that the pointer names. Row code 0 is row 1 and code 6 is row 7. `din[7:5]` are ignored.
- R4: Within a row, bit 4 is the leftmost dot column and bit 0 is the rightmost. The row is returned unchanged, in the same bit positions, on `scan_dots` and on `host_rdata[4:0]`.
- R5: Row code 7 is not a row. A write to it changes nothing, and a read of it returns 0 on both read ports.
- R6: A write commits only when the sampled `wr_n` goes from 0 to 1. During the low sample, `cs_n` must have been 0, `rd_n` must have been 1 and `host_rst_n` must have been 1. The address and data used are the ones sampled while `wr_n` was low. A strobe with `rd_n` also low, or with `cs_n` high, changes nothing.
- R7: An access with `region_sel`=0, or with `addr[4]`=1, writes nothing and reads back 0.
- R8: A read is an edge where `cs_n`=0, `rd_n`=0, `wr_n`=1 and `host_rst_n`=1. It loads `host_rdata` at that edge. At every other edge, `host_rdata` holds its value.
- R9: `scan_dots` is a combinational function of `scan_slot`, `scan_row` and the stored rows.
- R10: The slot pointer keeps its value through row writes, so the seven row writes that follow one pointer write all land in the same slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| host_rst_n | input | 1 | Active-low reset, sampled synchronously |
| region_sel | input | 1 | High selects the glyph store regions |
| addr | input | 5 | [4:3] picks the region, [2:0] picks the row |
| din | input | 8 | Host write data |
| cs_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| host_rdata | output | 8 | Registered host read data |
| scan_slot | input | 4 | Scanner slot number |
| scan_row | input | 3 | Scanner row code |
| scan_dots | output | 5 | Scanner row dots, bit 4 leftmost |

## Verification
The bench fills all sixteen slots with row values that are computed from the slot and row numbers, with junk in the ignored upper data bits. It then sweeps the scanner port across every slot and every row code. This separates slot addressing, row addressing, bit order and the row-7 rule. Slot 9 receives the F pattern, which tells a mirrored bit order apart from a correct one. Host readback is tried for the pointer and for the rows of several slots. Strobes that should be rejected are each followed by a readback that shows whether they slipped through: an overlapping read, a deasserted chip enable, a wrong region and row code 7.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_PTR  = 2'd1,
    REG_ROW  = 2'd2
  } region_e;

  function automatic region_e decode_region(input logic sel, input logic hi, input logic lo);
    if (!sel || hi) return REG_NONE;
    return lo ? REG_ROW : REG_PTR;
  endfunction
endpackage

// File: rtl/ccr_host_if.sv
module ccr_host_if import ccr_pkg::*; #(
  parameter int ROW_W  = 3,
  parameter int DW     = 8,
  localparam int AW    = ROW_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  output logic             ptr_we,
  output logic             row_we,
  output logic [ROW_W-1:0] wr_row,
  output logic [DW-1:0]    wr_data,
  output logic             rd_take,
  output region_e          rd_region,
  output logic [ROW_W-1:0] rd_row
);
  localparam logic [ROW_W-1:0] ROW_NONE = '1;

  logic             q_wr_n, q_rd_n, q_cs_n, q_sel;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_data;
  logic             commit;
  region_e          wr_region;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_wr_n <= 1'b1;
      q_rd_n <= 1'b1;
      q_cs_n <= 1'b1;
      q_sel  <= 1'b0;
      q_addr <= '0;
      q_data <= '0;
    end else begin
      q_wr_n <= wr_n;
      q_rd_n <= rd_n;
      q_cs_n <= cs_n;
      q_sel  <= sel;
      q_addr <= addr;
      q_data <= din;
    end
  end

  assign commit    = rst_n && wr_n && !q_wr_n && !q_cs_n && q_rd_n;
  assign wr_region = decode_region(q_sel, q_addr[AW-1], q_addr[AW-2]);
  assign wr_row    = q_addr[ROW_W-1:0];
  assign wr_data   = q_data;
  assign ptr_we    = commit && (wr_region == REG_PTR);
  assign row_we    = commit && (wr_region == REG_ROW) && (wr_row != ROW_NONE);

  assign rd_take   = rst_n && !cs_n && !rd_n && wr_n;
  assign rd_region = decode_region(sel, addr[AW-1], addr[AW-2]);
  assign rd_row    = addr[ROW_W-1:0];

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_we, row_we})); // R6
  AST_WRITE_NEEDS_STROBE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we || row_we) |-> (wr_n && $past(!wr_n))); // R6
  AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we || row_we) |-> $past(sel && !addr[AW-1])); // R7
endmodule

// File: rtl/ccr_slot_ptr.sv
module ccr_slot_ptr #(
  parameter int SLOT_W = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (!rst_n)  slot <= '0;
    else if (we) slot <= wdata[SLOT_W-1:0];
  end

  AST_PTR_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (slot == '0)); // R1
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !we) |=> $stable(slot)); // R10
endmodule

// File: rtl/ccr_glyph_mem.sv
module ccr_glyph_mem #(
  parameter int SLOT_W = 4,
  parameter int ROW_W  = 3,
  parameter int COLS   = 5,
  localparam int DEPTH = (1 << (SLOT_W + ROW_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] w_slot,
  input  logic [ROW_W-1:0]  w_row,
  input  logic [COLS-1:0]   w_dots,
  input  logic [SLOT_W-1:0] a_slot,
  input  logic [ROW_W-1:0]  a_row,
  output logic [COLS-1:0]   a_dots,
  input  logic [SLOT_W-1:0] b_slot,
  input  logic [ROW_W-1:0]  b_row,
  output logic [COLS-1:0]   b_dots
);
  localparam logic [ROW_W-1:0] ROW_NONE = '1;

  logic [COLS-1:0] store [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) store[{w_slot, w_row}] <= w_dots;
  end

  assign a_dots = (a_row == ROW_NONE) ? '0 : store[{a_slot, a_row}];
  assign b_dots = (b_row == ROW_NONE) ? '0 : store[{b_slot, b_row}];

  AST_SPARE_ROW_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (w_row != ROW_NONE)); // R5
  AST_SPARE_ROW_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (b_row == ROW_NONE) |-> (b_dots == '0)); // R5
endmodule

// File: rtl/glyph_ram_port.sv
module glyph_ram_port import ccr_pkg::*; #(
  parameter int SLOTS  = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  parameter int DW     = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ROW_W  = $clog2(ROWS + 1),
  localparam int AW     = ROW_W + 2
) (
  input  logic              clk,
  input  logic              host_rst_n,
  input  logic              region_sel,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  output logic [DW-1:0]     host_rdata,
  input  logic [SLOT_W-1:0] scan_slot,
  input  logic [ROW_W-1:0]  scan_row,
  output logic [COLS-1:0]   scan_dots
);
  logic             ptr_we, row_we, rd_take;
  logic [ROW_W-1:0] wr_row, rd_row;
  logic [DW-1:0]    wr_data;
  region_e          rd_region;
  logic [SLOT_W-1:0] slot;
  logic [COLS-1:0]  host_dots;
  logic [DW-1:0]    rd_next;

  ccr_host_if #(.ROW_W(ROW_W), .DW(DW)) u_if (
    .clk(clk), .rst_n(host_rst_n), .sel(region_sel), .addr(addr), .din(din),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .ptr_we(ptr_we), .row_we(row_we), .wr_row(wr_row), .wr_data(wr_data),
    .rd_take(rd_take), .rd_region(rd_region), .rd_row(rd_row)
  );

  ccr_slot_ptr #(.SLOT_W(SLOT_W), .DW(DW)) u_ptr (
    .clk(clk), .rst_n(host_rst_n), .we(ptr_we), .wdata(wr_data), .slot(slot)
  );

  ccr_glyph_mem #(.SLOT_W(SLOT_W), .ROW_W(ROW_W), .COLS(COLS)) u_mem (
    .clk(clk), .rst_n(host_rst_n),
    .we(row_we), .w_slot(slot), .w_row(wr_row), .w_dots(wr_data[COLS-1:0]),
    .a_slot(slot), .a_row(rd_row), .a_dots(host_dots),
    .b_slot(scan_slot), .b_row(scan_row), .b_dots(scan_dots)
  );

  always_comb begin
    rd_next = '0;
    case (rd_region)
      REG_PTR: rd_next[SLOT_W-1:0] = slot;
      REG_ROW: rd_next[COLS-1:0]   = host_dots;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!host_rst_n)  host_rdata <= '0;
    else if (rd_take) host_rdata <= rd_next;
  end

  AST_RDATA_CLEARS: assert property (@(posedge clk)
    !host_rst_n |=> (host_rdata == '0)); // R1
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!host_rst_n)
    !(!cs_n && !rd_n && wr_n) |=> $stable(host_rdata)); // R8
  AST_PTR_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!host_rst_n)
    (rd_take && rd_region == REG_PTR) |=> (host_rdata[DW-1:SLOT_W] == '0)); // R2
endmodule

// File: tb/sim_glyph_ram_port.sv
module sim_glyph_ram_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, host_rst_n = 0, region_sel = 0, cs_n = 1, wr_n = 1, rd_n = 1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0, host_rdata;
  logic [3:0] scan_slot = '0;
  logic [2:0] scan_row = '0;
  logic [4:0] scan_dots;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_ram_port u0 (.*);

  function automatic logic [4:0] pat(input int s, input int r);
    logic [4:0] f [7] = '{5'h1F, 5'h10, 5'h10, 5'h1E, 5'h10, 5'h10, 5'h10};
    if (r == 7) return 5'h0;
    if (s == 9) return f[r];
    return 5'((s * 7 + r * 11 + 3) % 32);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [4:0] a, input logic [7:0] d,
                           input logic csn = 0, input logic rdn = 1);
    @(negedge clk); region_sel = sel; addr = a; din = d; cs_n = csn; rd_n = rdn; wr_n = 0;
    @(negedge clk);
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic bus_read(input logic sel, input logic [4:0] a, output logic [7:0] q);
    @(negedge clk); region_sel = sel; addr = a; cs_n = 0; rd_n = 0; wr_n = 1;
    @(negedge clk); q = host_rdata; cs_n = 1; rd_n = 1;
  endtask

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", host_rdata, 0);
    host_rst_n = 1;
    bus_read(1, 5'b00000, q);
    check("R1 pointer after reset", q, 0);

    for (int s = 0; s < 16; s++) begin
      bus_write(1, 5'b00101, {4'hA, 4'(s)});
      for (int r = 0; r < 7; r++) bus_write(1, {2'b01, 3'(r)}, {3'b110, pat(s, r)});
      bus_write(1, 5'b01111, 8'hFF);
      bus_read(1, 5'b00000, q);
      check("R2/R10 pointer after row writes", q, s);
    end

    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 8; r++) begin
        @(negedge clk); scan_slot = 4'(s); scan_row = 3'(r); #1;
        check(r == 7 ? "R5 scan spare row" : "R3/R9 scan row", scan_dots, pat(s, r));
      end
    @(negedge clk); scan_slot = 9; scan_row = 3; #1;
    check("R4 F row 4 leftmost bit", scan_dots[4], 1);
    check("R4 F row 4 rightmost bit", scan_dots[0], 0);

    foreach (q[i]) ;
    for (int s = 3; s < 16; s += 6) begin
      bus_write(1, 5'b00000, 8'(s));
      for (int r = 0; r < 8; r++) begin
        bus_read(1, {2'b01, 3'(r)}, q);
        check("R8/R4 host row read", q, pat(s, r));
      end
    end

    bus_write(1, 5'b00000, 8'h02);
    bus_write(1, 5'b00000, 8'h07, 0, 0);
    bus_read(1, 5'b00000, q);
    check("R6 overlapped read blocks write", q, 2);
    bus_write(1, 5'b00000, 8'h07, 1, 1);
    bus_read(1, 5'b00000, q);
    check("R6 chip enable high blocks write", q, 2);
    bus_write(0, 5'b01000, 8'h00);
    bus_write(1, 5'b11000, 8'h00);
    bus_write(0, 5'b00000, 8'h05);
    bus_read(1, 5'b01000, q);
    check("R7 outside region writes nothing", q, pat(2, 0));
    bus_read(1, 5'b00000, q);
    check("R7 outside region pointer kept", q, 2);
    bus_read(0, 5'b01000, q);
    check("R7 select low reads zero", q, 0);
    bus_read(1, 5'b11000, q);
    check("R7 high region reads zero", q, 0);
    bus_read(1, 5'b01000, q);
    @(negedge clk); addr = 5'b00000; region_sel = 1;
    @(negedge clk);
    check("R8 rdata holds without read", host_rdata, pat(2, 0));
    @(negedge clk); host_rst_n = 0;
    @(negedge clk); host_rst_n = 1;
    check("R1 rdata cleared by reset", host_rdata, 0);
    bus_read(1, 5'b00000, q);
    check("R1 pointer cleared by reset", q, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); fails++; checks++;
        $display("FAIL watchdog actual=running expected=done"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule